// File: doc/BRIEF.md
# Microprogrammed Control Unit Sequencer

This block generates the ten datapath control signals of a simple stored-program processor. It reads them from a small read-only control store rather than building them from random logic. Each cycle a micro-address register picks one control store word. That word is copied into a microinstruction buffer, and each of the ten low bits of the buffer drives exactly one control signal pin. A sequencer chooses the next micro-address from four sequencing modes held in the buffered word: step by one, opcode dispatch, return to fetch, or conditional skip on a selected status flag.

The microprogram starts with three fetch words at micro-addresses 0, 1 and 2. The first places the program counter on Bus1, passes it through the ALU into the memory address register and starts a memory read. The second adds the constant one to the program counter. The third passes the memory buffer through the ALU into the instruction register. The third word then dispatches on the opcode to a short routine for that opcode. Every routine ends by returning to micro-address 0.

Two states control the block. `S_BOOT` is entered by reset; the buffer is clear and no signal is active. On the first clock edge after reset is released, the transition `S_BOOT -> S_RUN` loads fetch word 0. `S_RUN` then loops on itself: every edge loads the word selected by the sequencer mode of the current word. The four modes are `SQ_NEXT` (address plus one), `SQ_DISP` (dispatch table), `SQ_FETCH` (address 0) and `SQ_SKIP` (plus two when the selected flag is 1, else plus one).

Top module: `ucu_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until the next rising clock edge, all ten control outputs are 0.
- R2: The control word is observed as {pc_to_bus1, one_to_bus2, mbr_to_bus2, alu_pass1, alu_add, alu_pass2, bus3_to_pc, bus3_to_ir, bus3_to_mar, mem_read} (bit 9 down to bit 0). Fetch emits 10'b1001000011, then 10'b1100101000, then 10'b0010010100 on three consecutive cycles, starting at the first edge after reset.
- R3: The cycle after the last word of any routine emits the first fetch word 10'b1001000011 again.
- R4: The word after the third fetch word is the first word of the routine chosen by the opcode sampled at the clock edge that ends the third fetch word.
- R5: Opcodes 0, 6 and 7 run a single all-zero word.
- R6: Opcode 1 runs 10'b1001000011 then 10'b0010011000 (memory buffer through ALU into the program counter).
- R7: Opcodes 2 and 3 run an all-zero test word. The test flag is `flags[0]` for opcode 2 and `flags[3]` for opcode 3, sampled at the edge that ends the test word. When the flag is 1, one all-zero word follows. When it is 0, one word follows: 10'b1100101000 for opcode 2, or 10'b1100100010 for opcode 3.
- R8: Opcode 4 runs 10'b1100101000 twice. Opcode 5 runs 10'b1001000010 once.
- R9: `flags` has no effect except at the edge that ends a test word. `opcode` has no effect except at the dispatch edge.
- R10: Asserting `rst_n` in the middle of a routine clears all outputs at once. After release, fetch restarts from its first word.
- R11: No word drives both Bus2 sources at once, and no word selects more than one ALU operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPW | Opcode field of the instruction register |
| flags | input | 4 | Status flags: bit 0 zero, bit 1 negative, bit 2 overflow, bit 3 carry |
| pc_to_bus1 | output | 1 | Program counter onto Bus1 |
| one_to_bus2 | output | 1 | Constant one onto Bus2 |
| mbr_to_bus2 | output | 1 | Memory buffer onto Bus2 |
| alu_pass1 | output | 1 | ALU copies Bus1 to Bus3 |
| alu_add | output | 1 | ALU adds Bus1 and Bus2 onto Bus3 |
| alu_pass2 | output | 1 | ALU copies Bus2 to Bus3 |
| bus3_to_pc | output | 1 | Load program counter from Bus3 |
| bus3_to_ir | output | 1 | Load instruction register from Bus3 |
| bus3_to_mar | output | 1 | Load memory address register from Bus3 |
| mem_read | output | 1 | Start a memory read into the memory buffer |

## Verification
The assertions assume that `opcode` already carries the new instruction at the edge that ends the third fetch word. This is the value Bus3 delivers to the instruction register, so the block sees it as the register's output. They also assume `flags` is settled at the edge that ends a test word. The bench drives both inputs on the falling edge, several cycles before the edges that sample them. In scrambled runs it inverts them only after those edges have passed, which checks that later changes have no effect. Reset is asserted and released on falling edges only.

// File: rtl/ucu_pkg.sv
package ucu_pkg;

    localparam int CTLW  = 10;
    localparam int NFLAG = 4;
    localparam int FSW   = $clog2(NFLAG);

    // flag positions
    localparam int FL_Z = 0;
    localparam int FL_N = 1;
    localparam int FL_V = 2;
    localparam int FL_C = 3;

    // control bit positions, high to low
    localparam int B_PC_B1  = 9;
    localparam int B_ONE_B2 = 8;
    localparam int B_MBR_B2 = 7;
    localparam int B_PASS1  = 6;
    localparam int B_ADD    = 5;
    localparam int B_PASS2  = 4;
    localparam int B_LD_PC  = 3;
    localparam int B_LD_IR  = 2;
    localparam int B_LD_MAR = 1;
    localparam int B_RD     = 0;

    // control words
    localparam logic [CTLW-1:0] W_IDLE  = 10'b00000_00000;
    localparam logic [CTLW-1:0] W_T0    = 10'b10010_00011;
    localparam logic [CTLW-1:0] W_T1    = 10'b11001_01000;
    localparam logic [CTLW-1:0] W_T2    = 10'b00100_10100;
    localparam logic [CTLW-1:0] W_MB2PC = 10'b00100_11000;
    localparam logic [CTLW-1:0] W_INC2M = 10'b11001_00010;
    localparam logic [CTLW-1:0] W_PC2M  = 10'b10010_00010;

    // microprogram layout
    localparam int A_FETCH = 0;
    localparam int A_NOP   = 3;
    localparam int A_LDPC  = 4;
    localparam int A_SKZ   = 6;
    localparam int A_SKC   = 9;
    localparam int A_INC2  = 12;
    localparam int A_MAR   = 14;
    localparam int A_LAST  = 14;

    typedef enum logic [1:0] {
        SQ_NEXT  = 2'd0,
        SQ_DISP  = 2'd1,
        SQ_FETCH = 2'd2,
        SQ_SKIP  = 2'd3
    } seq_mode_e;

    typedef enum logic {
        S_BOOT = 1'b0,
        S_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        seq_mode_e        mode;
        logic [FSW-1:0]   fsel;
        logic [CTLW-1:0]  ctl;
    } uword_t;

    function automatic uword_t mk_word(seq_mode_e m, logic [FSW-1:0] f,
                                       logic [CTLW-1:0] c);
        uword_t w;
        w.mode = m;
        w.fsel = f;
        w.ctl  = c;
        return w;
    endfunction

endpackage

// File: rtl/ucu_store.sv
module ucu_store
    import ucu_pkg::*;
#(
    parameter int UAW = 5
) (
    input  logic [UAW-1:0] addr,
    output uword_t         word
);

    localparam logic [FSW-1:0] FZ = FSW'(FL_Z);
    localparam logic [FSW-1:0] FC = FSW'(FL_C);
    localparam logic [FSW-1:0] F0 = '0;

    always_comb begin
        word = mk_word(SQ_FETCH, F0, W_IDLE);
        case (addr)
            UAW'(A_FETCH):     word = mk_word(SQ_NEXT,  F0, W_T0);
            UAW'(A_FETCH + 1): word = mk_word(SQ_NEXT,  F0, W_T1);
            UAW'(A_FETCH + 2): word = mk_word(SQ_DISP,  F0, W_T2);
            UAW'(A_NOP):       word = mk_word(SQ_FETCH, F0, W_IDLE);
            UAW'(A_LDPC):      word = mk_word(SQ_NEXT,  F0, W_T0);
            UAW'(A_LDPC + 1):  word = mk_word(SQ_FETCH, F0, W_MB2PC);
            UAW'(A_SKZ):       word = mk_word(SQ_SKIP,  FZ, W_IDLE);
            UAW'(A_SKZ + 1):   word = mk_word(SQ_FETCH, F0, W_T1);
            UAW'(A_SKZ + 2):   word = mk_word(SQ_FETCH, F0, W_IDLE);
            UAW'(A_SKC):       word = mk_word(SQ_SKIP,  FC, W_IDLE);
            UAW'(A_SKC + 1):   word = mk_word(SQ_FETCH, F0, W_INC2M);
            UAW'(A_SKC + 2):   word = mk_word(SQ_FETCH, F0, W_IDLE);
            UAW'(A_INC2):      word = mk_word(SQ_NEXT,  F0, W_T1);
            UAW'(A_INC2 + 1):  word = mk_word(SQ_FETCH, F0, W_T1);
            UAW'(A_MAR):       word = mk_word(SQ_FETCH, F0, W_PC2M);
            default:           word = mk_word(SQ_FETCH, F0, W_IDLE);
        endcase
    end

endmodule

// File: rtl/ucu_dispatch.sv
module ucu_dispatch
    import ucu_pkg::*;
#(
    parameter int OPW = 3,
    parameter int UAW = 5
) (
    input  logic [OPW-1:0] opcode,
    output logic [UAW-1:0] target
);

    always_comb begin
        case (opcode)
            OPW'(1):  target = UAW'(A_LDPC);
            OPW'(2):  target = UAW'(A_SKZ);
            OPW'(3):  target = UAW'(A_SKC);
            OPW'(4):  target = UAW'(A_INC2);
            OPW'(5):  target = UAW'(A_MAR);
            default:  target = UAW'(A_NOP);
        endcase
    end

endmodule

// File: rtl/ucu_sequencer.sv
module ucu_sequencer
    import ucu_pkg::*;
#(
    parameter int UAW = 5
) (
    input  run_state_e       st,
    input  seq_mode_e        mode,
    input  logic [FSW-1:0]   fsel,
    input  logic [UAW-1:0]   upc,
    input  logic [UAW-1:0]   target,
    input  logic [NFLAG-1:0] flags,
    output logic [UAW-1:0]   upc_next
);

    logic [UAW-1:0] step1;
    logic [UAW-1:0] step2;

    assign step1 = upc + UAW'(1);
    assign step2 = upc + UAW'(2);

    always_comb begin
        unique case (st)
            S_BOOT: upc_next = UAW'(A_FETCH);
            S_RUN: begin
                unique case (mode)
                    SQ_NEXT:  upc_next = step1;
                    SQ_DISP:  upc_next = target;
                    SQ_FETCH: upc_next = UAW'(A_FETCH);
                    SQ_SKIP:  upc_next = flags[fsel] ? step2 : step1;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ucu_ctrl.sv
module ucu_ctrl
    import ucu_pkg::*;
#(
    parameter int OPW = 3,
    parameter int UAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic [3:0]     flags,
    output logic           pc_to_bus1,
    output logic           one_to_bus2,
    output logic           mbr_to_bus2,
    output logic           alu_pass1,
    output logic           alu_add,
    output logic           alu_pass2,
    output logic           bus3_to_pc,
    output logic           bus3_to_ir,
    output logic           bus3_to_mar,
    output logic           mem_read
);

    run_state_e     st;
    logic [UAW-1:0] upc;
    logic [UAW-1:0] upc_next;
    logic [UAW-1:0] target;
    uword_t         mib;
    uword_t         rd_word;

    ucu_store #(.UAW(UAW)) store_i (
        .addr (upc_next),
        .word (rd_word)
    );

    ucu_dispatch #(.OPW(OPW), .UAW(UAW)) disp_i (
        .opcode (opcode),
        .target (target)
    );

    ucu_sequencer #(.UAW(UAW)) seq_i (
        .st       (st),
        .mode     (mib.mode),
        .fsel     (mib.fsel),
        .upc      (upc),
        .target   (target),
        .flags    (flags),
        .upc_next (upc_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_BOOT;
        end else begin
            unique case (st)
                S_BOOT: st <= S_RUN;
                S_RUN:  st <= S_RUN;
            endcase
        end
    end

    // micro-address register and microinstruction buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc <= '0;
            mib <= '0;
        end else begin
            upc <= upc_next;
            mib <= rd_word;
        end
    end

    // outputs: one buffer bit per signal
    always_comb begin
        pc_to_bus1  = mib.ctl[B_PC_B1];
        one_to_bus2 = mib.ctl[B_ONE_B2];
        mbr_to_bus2 = mib.ctl[B_MBR_B2];
        alu_pass1   = mib.ctl[B_PASS1];
        alu_add     = mib.ctl[B_ADD];
        alu_pass2   = mib.ctl[B_PASS2];
        bus3_to_pc  = mib.ctl[B_LD_PC];
        bus3_to_ir  = mib.ctl[B_LD_IR];
        bus3_to_mar = mib.ctl[B_LD_MAR];
        mem_read    = mib.ctl[B_RD];
    end

    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BOOT) |-> (mib.ctl == W_IDLE)); // R1

    AST_BOOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BOOT) |=> (upc == UAW'(A_FETCH) && mib.ctl == W_T0)); // R2

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && upc == UAW'(A_FETCH)) |=> (upc == UAW'(A_FETCH + 1) && mib.ctl == W_T1)); // R2

    AST_FETCH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && upc == UAW'(A_FETCH + 1)) |=> (upc == UAW'(A_FETCH + 2) && mib.ctl == W_T2)); // R2

    AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && upc == UAW'(A_FETCH + 2)) |=> (upc >= UAW'(A_NOP) && upc <= UAW'(A_LAST))); // R4

    AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && mib.mode == SQ_FETCH) |=> (upc == UAW'(A_FETCH) && mib.ctl == W_T0)); // R3

    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && mib.mode == SQ_SKIP) |=> (upc == $past(upc) + UAW'(1) || upc == $past(upc) + UAW'(2))); // R7

    AST_BUS2_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({one_to_bus2, mbr_to_bus2})); // R11

    AST_ALU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_pass1, alu_add, alu_pass2})); // R11

endmodule

// File: tb/ucu_ctrl_tb.sv
module ucu_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] E_T0    = 10'b1001000011;
    localparam logic [9:0] E_T1    = 10'b1100101000;
    localparam logic [9:0] E_T2    = 10'b0010010100;
    localparam logic [9:0] E_ZERO  = 10'b0000000000;
    localparam logic [9:0] E_MB2PC = 10'b0010011000;
    localparam logic [9:0] E_INC2M = 10'b1100100010;
    localparam logic [9:0] E_PC2M  = 10'b1001000010;

    logic       clk;
    logic       rst_n;
    logic [2:0] opcode;
    logic [3:0] flags;
    logic pc_to_bus1, one_to_bus2, mbr_to_bus2, alu_pass1, alu_add, alu_pass2;
    logic bus3_to_pc, bus3_to_ir, bus3_to_mar, mem_read;
    logic [9:0] obs;

    int n_tests = 0;
    int n_fail  = 0;

    ucu_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode      (opcode),
        .flags       (flags),
        .pc_to_bus1  (pc_to_bus1),
        .one_to_bus2 (one_to_bus2),
        .mbr_to_bus2 (mbr_to_bus2),
        .alu_pass1   (alu_pass1),
        .alu_add     (alu_add),
        .alu_pass2   (alu_pass2),
        .bus3_to_pc  (bus3_to_pc),
        .bus3_to_ir  (bus3_to_ir),
        .bus3_to_mar (bus3_to_mar),
        .mem_read    (mem_read)
    );

    assign obs = {pc_to_bus1, one_to_bus2, mbr_to_bus2, alu_pass1, alu_add,
                  alu_pass2, bus3_to_pc, bus3_to_ir, bus3_to_mar, mem_read};

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check_word(input logic [9:0] exp, input string tag);
        n_tests++;
        if (obs !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, obs, exp);
        end
    endtask

    // expected routine from the requirement table
    task automatic expect_routine(input logic [2:0] op, input logic [3:0] fl,
                                  output int n, output logic [9:0] w0,
                                  output logic [9:0] w1, output string tag);
        n = 1; w0 = E_ZERO; w1 = E_ZERO; tag = "R5 nop routine";
        case (op)
            3'd1: begin n = 2; w0 = E_T0; w1 = E_MB2PC; tag = "R6 load pc routine"; end
            3'd2: begin n = 2; w0 = E_ZERO; w1 = fl[0] ? E_ZERO : E_T1; tag = "R7 zero skip routine"; end
            3'd3: begin n = 2; w0 = E_ZERO; w1 = fl[3] ? E_ZERO : E_INC2M; tag = "R7 carry skip routine"; end
            3'd4: begin n = 2; w0 = E_T1; w1 = E_T1; tag = "R8 double inc routine"; end
            3'd5: begin n = 1; w0 = E_PC2M; tag = "R8 pc to mar routine"; end
            default: ;
        endcase
    endtask

    // entered at a falling edge where the first fetch word is visible
    task automatic do_instr(input logic [2:0] op, input logic [3:0] fl, input bit scram);
        int n;
        logic [9:0] w0, w1;
        string tag;
        opcode = op;
        flags  = fl;
        check_word(E_T0, "R3 fetch word 0");
        @(negedge clk);
        check_word(E_T1, "R2 fetch word 1");
        if (scram) flags = ~fl;
        @(negedge clk);
        check_word(E_T2, "R2 fetch word 2");
        if (scram) flags = fl;
        @(negedge clk);
        expect_routine(op, fl, n, w0, w1, tag);
        for (int i = 0; i < n; i++) begin
            check_word(i == 0 ? w0 : w1, scram ? {"R9 ", tag} : {"R4 ", tag});
            if (scram && i == 0) begin
                opcode = ~op;
                if (op != 3'd2 && op != 3'd3) flags = ~fl;
            end
            if (scram && i == 1) flags = ~fl;
            @(negedge clk);
        end
    endtask

    task automatic reset_mid;
        opcode = 3'd1;
        flags  = 4'd0;
        check_word(E_T0, "R3 fetch word 0");
        repeat (3) @(negedge clk);
        check_word(E_T0, "R6 first word before reset");
        rst_n = 1'b0;
        #1;
        check_word(E_ZERO, "R10 outputs clear on reset");
        @(negedge clk);
        check_word(E_ZERO, "R10 outputs held clear");
        rst_n = 1'b1;
        #1;
        check_word(E_ZERO, "R1 clear before first edge");
        @(negedge clk);
        check_word(E_T0, "R10 fetch restarts");
    endtask

    initial begin
        rst_n  = 1'b0;
        opcode = 3'd0;
        flags  = 4'd0;
        repeat (2) @(negedge clk);
        check_word(E_ZERO, "R1 reset state");
        rst_n = 1'b1;
        #1;
        check_word(E_ZERO, "R1 after release before edge");
        @(negedge clk);
        for (int op = 0; op < 8; op++) do_instr(3'(op), 4'b0000, 1'b0);
        do_instr(3'd2, 4'b0001, 1'b0);
        do_instr(3'd2, 4'b1110, 1'b0);
        do_instr(3'd3, 4'b1000, 1'b0);
        do_instr(3'd3, 4'b0111, 1'b0);
        do_instr(3'd4, 4'b0101, 1'b1);
        do_instr(3'd1, 4'b1010, 1'b1);
        do_instr(3'd2, 4'b0001, 1'b1);
        do_instr(3'd3, 4'b0000, 1'b1);
        do_instr(3'd0, 4'b1111, 1'b1);
        reset_mid();
        do_instr(3'd5, 4'b0011, 1'b0);
        do_instr(3'd6, 4'b0000, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule